// File: doc/BRIEF.md
# Clock Source Control Register

This block is an 8-bit control register that sits on a simple register bus. It has one write-enable and one read-enable strobe, and it decodes a single address. Software uses it for two things: to switch on the high-speed oscillator, and to choose whether the system runs from the low-speed clock or from the divided high-speed clock.

A read-only lock flag tells software when the high-speed source may be used. The flag rises only after a stabilization wait has run out. The wait is counted in reference-clock cycles and its length is set by a parameter. Software may request the high-speed clock before lock. The request is kept in the register, but the effective select output stays on the low-speed clock until the lock flag is 1.

A 2-bit divider code arrives from a companion register. The block passes it on, capped so that a PLL source is never used undivided. From the capped code it also makes a one-cycle enable pulse at the divided rate. The oscillator, the PLL and the glitch-free clock multiplexer sit outside the block; it drives only their control signals. Every pin is a plain control or status signal. No data stream passes through the block, so it has no valid/ready handshake.

Top module: `clksrc_ctrl_unit`

## Requirements
- R1: After reset, a read of the register returns 0x00, and `osc_en_o`, `sys_sel_hs_o` and `hs_clk_en_o` are all 0.
- R2: A write with `bus_wr` high at address `REG_ADDR` updates the register at that clock edge. Bit 1 of the register drives `osc_en_o`. A write to any other address changes nothing. `bus_rdata` is 0 unless `bus_rd` is high and the address matches. While both hold, `bus_rdata` is the register value in the same cycle.
- R3: Bit 0 is the select request (1 = high-speed). Whenever bit 1 is 0, bit 0 is stored and read back as 0, whatever value was written.
- R4: Bits 6 to 2 always read 0, and writes to them are ignored. A write to bit 7 is also ignored.
- R5: Bit 7 reads 1 exactly `STAB_CYCLES` clock edges after the edge that changed bit 1 from 0 to 1. Writing bit 1 as 1 when it is already 1 does not restart the wait. Writing bit 1 as 0 clears bit 7 in the cycle right after that write edge, and the next enable starts the full wait again.
- R6: `sys_sel_hs_o` is 1 only when bit 0, bit 1 and bit 7 are all 1. A select request made before lock can be read back as bit 0 = 1 while `sys_sel_hs_o` stays 0.
- R7: With `pll_src_i` low, `div_code_o` equals `div_code_i`. The code values are 0 = divide by 1, 1 = by 2, 2 = by 4 and 3 = by 8.
- R8: With `pll_src_i` high, a requested code 0 is output as code 1 (divide by 2). Codes 1 to 3 pass unchanged.
- R9: While `osc_en_o` is 1, `hs_clk_en_o` is high on exactly one cycle in every n, where n is the divisor of `div_code_o`. While `osc_en_o` is 0, `hs_clk_en_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational |
| div_code_i | input | 2 | Divider code from the companion register |
| pll_src_i | input | 1 | High-speed source is the PLL |
| osc_en_o | output | 1 | Oscillator enable |
| sys_sel_hs_o | output | 1 | Effective system clock select (1 = high-speed) |
| div_code_o | output | 2 | Capped divider code |
| hs_clk_en_o | output | 1 | Divided-clock enable pulse |

## Verification
Writes are driven from a table of bytes, each paired with the readback expected before lock. The bytes mix the select bit with the enable bit both low and high, and set the reserved bits and bit 7. This separates the select masking from the reserved-bit masking. The same table walks every divider code with the PLL source flag both low and high, so the cap is told apart from a plain pass-through. Directed runs check the readback on the cycle before and the cycle of the lock edge, both after a first enable and after a disable and re-enable. This catches an off-by-one count and a counter that is not restarted. The enable pulses are counted over a 24-cycle window for every divisor, which catches a wrong period or pulses that leak out while the oscillator is off.

// File: rtl/clksrc_pkg.sv
package clksrc_pkg;
  localparam int REG_W    = 8;
  localparam int BIT_SEL  = 0;
  localparam int BIT_EN   = 1;
  localparam int BIT_LOCK = 7;

  typedef enum logic [1:0] {
    DIV_BY1 = 2'd0,
    DIV_BY2 = 2'd1,
    DIV_BY4 = 2'd2,
    DIV_BY8 = 2'd3
  } div_code_e;

  function automatic logic [1:0] cap_div(input logic [1:0] req, input logic pll);
    if (pll && req == DIV_BY1) return DIV_BY2;
    return req;
  endfunction
endpackage

// File: rtl/clksrc_regfile.sv
module clksrc_regfile
  import clksrc_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter logic [ADDR_W-1:0] REG_ADDR = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [REG_W-1:0]  bus_wdata,
  input  logic              lock_i,
  output logic [REG_W-1:0]  bus_rdata,
  output logic              en_q,
  output logic              sel_q
);
  logic hit;
  logic [REG_W-1:0] rd_word;

  assign hit = (bus_addr == REG_ADDR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      sel_q <= 1'b0;
    end else if (bus_wr && hit) begin
      en_q  <= bus_wdata[BIT_EN];
      sel_q <= bus_wdata[BIT_EN] & bus_wdata[BIT_SEL];
    end
  end

  for (genvar b = 0; b < REG_W; b++) begin : g_rd
    if (b == BIT_SEL)       begin : g_s assign rd_word[b] = sel_q;  end
    else if (b == BIT_EN)   begin : g_e assign rd_word[b] = en_q;   end
    else if (b == BIT_LOCK) begin : g_l assign rd_word[b] = lock_i; end
    else                    begin : g_z assign rd_word[b] = 1'b0;   end
  end

  assign bus_rdata = (bus_rd && hit) ? rd_word : '0;

  AST_SEL_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    sel_q |-> en_q); // R3
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata[6:2] == 5'd0); // R4
  AST_NO_READ_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |-> bus_rdata == '0); // R2
endmodule

// File: rtl/clksrc_lock_timer.sv
module clksrc_lock_timer #(
  parameter int STAB_CYCLES = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  output logic lock_q
);
  localparam int CNT_W = $clog2(STAB_CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(STAB_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      lock_q <= 1'b0;
    end else if (!en_i) begin
      cnt_q  <= '0;
      lock_q <= 1'b0;
    end else if (!lock_q) begin
      if (cnt_q == LAST) lock_q <= 1'b1;
      else               cnt_q  <= cnt_q + 1'b1;
    end
  end

  AST_LOCK_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> !lock_q); // R5
  AST_LOCK_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q && en_i) |=> lock_q); // R5
endmodule

// File: rtl/clksrc_div_enable.sv
module clksrc_div_enable
  import clksrc_pkg::*;
#(
  parameter int DIV_CODES = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run_i,
  input  logic [1:0] code_i,
  output logic       pulse_o
);
  localparam int MAX_DIV = 1 << (DIV_CODES - 1);
  localparam int PH_W    = $clog2(MAX_DIV);

  logic [PH_W-1:0] phase_q;
  logic [PH_W-1:0] top_val;

  assign top_val = PH_W'((1 << code_i) - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                phase_q <= '0;
    else if (!run_i)           phase_q <= '0;
    else if (phase_q >= top_val) phase_q <= '0;
    else                       phase_q <= phase_q + 1'b1;
  end

  assign pulse_o = run_i && (phase_q == '0);

  AST_PULSE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |-> !pulse_o); // R9
  AST_DIV1_ALWAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && $past(run_i) && code_i == DIV_BY1 && $stable(code_i)) |-> pulse_o); // R9
endmodule

// File: rtl/clksrc_ctrl_unit.sv
module clksrc_ctrl_unit
  import clksrc_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter logic [ADDR_W-1:0] REG_ADDR = 4'h3,
  parameter int STAB_CYCLES = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic [1:0]        div_code_i,
  input  logic              pll_src_i,
  output logic              osc_en_o,
  output logic              sys_sel_hs_o,
  output logic [1:0]        div_code_o,
  output logic              hs_clk_en_o
);
  localparam int AGE_W = $clog2(STAB_CYCLES + 1);

  logic en_q, sel_q, lock_q, locked;

  clksrc_regfile #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_reg (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .lock_i(locked),
    .bus_rdata(bus_rdata), .en_q(en_q), .sel_q(sel_q)
  );

  clksrc_lock_timer #(.STAB_CYCLES(STAB_CYCLES)) u_lock (
    .clk(clk), .rst_n(rst_n), .en_i(en_q), .lock_q(lock_q)
  );

  assign locked       = lock_q & en_q;
  assign osc_en_o     = en_q;
  assign sys_sel_hs_o = sel_q & locked;
  assign div_code_o   = cap_div(div_code_i, pll_src_i);

  clksrc_div_enable u_div (
    .clk(clk), .rst_n(rst_n), .run_i(en_q), .code_i(div_code_o),
    .pulse_o(hs_clk_en_o)
  );

  // Checker: cycles elapsed since the oscillator was enabled, saturating.
  logic [AGE_W-1:0] age_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                            age_q <= '0;
    else if (!osc_en_o)                    age_q <= '0;
    else if (age_q != AGE_W'(STAB_CYCLES)) age_q <= age_q + 1'b1;
  end

  AST_LOCK_AFTER_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    locked |-> age_q >= AGE_W'(STAB_CYCLES)); // R5
  AST_SEL_NEEDS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    sys_sel_hs_o |-> (locked && osc_en_o)); // R6
  AST_PLL_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    pll_src_i |-> div_code_o != DIV_BY1); // R8
  AST_CODE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    !pll_src_i |-> div_code_o == div_code_i); // R7
endmodule

// File: tb/sim_clksrc_ctrl_unit.sv
module sim_clksrc_ctrl_unit;
  localparam int CLK_PERIOD = 10;
  localparam int STAB = 12;
  localparam logic [3:0] RA = 4'h3;

  logic clk = 0, rst_n = 0;
  logic [3:0] bus_addr = RA;
  logic bus_wr = 0, bus_rd = 0, pll_src_i = 0;
  logic [7:0] bus_wdata = 0, bus_rdata;
  logic [1:0] div_code_i = 0, div_code_o;
  logic osc_en_o, sys_sel_hs_o, hs_clk_en_o;
  int n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  clksrc_ctrl_unit #(.ADDR_W(4), .REG_ADDR(RA), .STAB_CYCLES(STAB)) u0 (.*);

  typedef struct packed {
    logic [7:0] wdata;
    logic [7:0] exp_rb;
    logic       pll;
    logic [1:0] code;
    logic [1:0] exp_div;
  } vec_t;

  localparam vec_t VEC [8] = '{
    '{8'h00, 8'h00, 1'b0, 2'd0, 2'd0},
    '{8'h01, 8'h00, 1'b0, 2'd1, 2'd1},
    '{8'h02, 8'h02, 1'b0, 2'd2, 2'd2},
    '{8'h03, 8'h03, 1'b0, 2'd3, 2'd3},
    '{8'h00, 8'h00, 1'b1, 2'd0, 2'd1},
    '{8'hFD, 8'h00, 1'b1, 2'd1, 2'd1},
    '{8'hFE, 8'h02, 1'b1, 2'd2, 2'd2},
    '{8'h7F, 8'h03, 1'b1, 2'd3, 2'd3}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk);
    bus_wr = 0; bus_addr = RA;
  endtask

  task automatic rd_reg(input logic [3:0] a, output logic [7:0] d);
    bus_addr = a; bus_rd = 1;
    #1 d = bus_rdata;
    bus_rd = 0; bus_addr = RA;
  endtask

  task automatic count_pulses(output int cnt);
    cnt = 0;
    repeat (8) @(negedge clk);
    for (int i = 0; i < 24; i++) begin
      @(negedge clk);
      cnt += int'(hs_clk_en_o);
    end
  endtask

  task automatic lock_wait(input logic [7:0] base, input string req);
    logic [7:0] r;
    for (int k = 1; k <= STAB; k++) begin
      @(negedge clk);
      if (k == STAB - 1) begin
        rd_reg(RA, r);
        chk({req, " pre-lock rb"}, r, base);
      end
      if (k == STAB) begin
        rd_reg(RA, r);
        chk({req, " lock rb"}, r, base | 8'h80);
      end
    end
  endtask

  function automatic string finish_line();
    return $sformatf("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endfunction

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display(finish_line());
    $finish;
  end

  initial begin
    logic [7:0] r;
    int p;
    repeat (3) @(negedge clk);
    // R1 reset state
    rd_reg(RA, r);
    chk("R1 rb", r, 8'h00);
    chk("R1 osc_en", {7'd0, osc_en_o}, 8'd0);
    chk("R1 sel", {7'd0, sys_sel_hs_o}, 8'd0);
    chk("R1 pulse", {7'd0, hs_clk_en_o}, 8'd0);
    rst_n = 1;

    // Table: R2 R3 R4 readback, R7 R8 divider cap
    foreach (VEC[i]) begin
      pll_src_i = VEC[i].pll;
      div_code_i = VEC[i].code;
      wr_reg(RA, VEC[i].wdata);
      rd_reg(RA, r);
      chk("R3/R4 table rb", r, VEC[i].exp_rb);
      chk("R2 table osc_en", {7'd0, osc_en_o}, {7'd0, VEC[i].exp_rb[1]});
      chk("R7/R8 table div", {6'd0, div_code_o}, {6'd0, VEC[i].exp_div});
      chk("R6 table sel pre-lock", {7'd0, sys_sel_hs_o}, 8'd0);
    end
    wr_reg(RA, 8'h00);
    pll_src_i = 0; div_code_i = 0;

    // R2 address decode
    wr_reg(RA + 4'd1, 8'h02);
    rd_reg(RA, r);
    chk("R2 other addr write ignored", r, 8'h00);
    wr_reg(RA, 8'h02);
    rd_reg(RA + 4'd1, r);
    chk("R2 other addr read zero", r, 8'h00);
    rd_reg(RA, r);
    chk("R2 own addr read", r, 8'h02);
    wr_reg(RA, 8'h00);

    // R5 R6 lock timing with early select request
    wr_reg(RA, 8'h03);
    chk("R6 sel held pre-lock", {7'd0, sys_sel_hs_o}, 8'd0);
    lock_wait(8'h03, "R5 first");
    chk("R6 sel after lock", {7'd0, sys_sel_hs_o}, 8'd1);
    wr_reg(RA, 8'h03);
    rd_reg(RA, r);
    chk("R5 rewrite keeps lock", r, 8'h83);
    wr_reg(RA, 8'h00);
    rd_reg(RA, r);
    chk("R5 clear at once", r, 8'h00);
    chk("R6 sel drops", {7'd0, sys_sel_hs_o}, 8'd0);

    // R5 restart
    wr_reg(RA, 8'h02);
    repeat (6) @(negedge clk);
    wr_reg(RA, 8'h00);
    wr_reg(RA, 8'h02);
    lock_wait(8'h02, "R5 restart");
    chk("R6 no request no sel", {7'd0, sys_sel_hs_o}, 8'd0);
    wr_reg(RA, 8'h83);
    chk("R6 late request sel", {7'd0, sys_sel_hs_o}, 8'd1);

    // R9 divided enable
    for (int c = 0; c < 4; c++) begin
      div_code_i = 2'(c);
      count_pulses(p);
      chk("R9 pulses", 8'(p), 8'(24 >> c));
    end
    pll_src_i = 1; div_code_i = 0;
    count_pulses(p);
    chk("R8/R9 capped pulses", 8'(p), 8'd12);
    wr_reg(RA, 8'h00);
    count_pulses(p);
    chk("R9 off no pulses", 8'(p), 8'd0);

    $display(finish_line());
    $finish;
  end
endmodule